// File: doc/BRIEF.md
# Per-Address Branch History Table with Shared Pattern Counters

This block predicts conditional branches from two levels of history. The first level is a tagged, set-associative table in which every static branch owns a shift register of its own recent outcomes. The second level is one pattern table of 2-bit saturating counters, shared by all branches and indexed by a branch's history. A resolve computes the prediction for the branch's next appearance and writes it into the entry. A later lookup then needs only one table read.

The fetch stage presents an address on the lookup port. One cycle later the block reports a hit, the predicted direction and the next fetch address. That address is the cached target on a predicted-taken hit, and the sequential address otherwise. The execute stage presents each resolved branch on the resolve port with its outcome and target. A resolve updates the branch's history, its stored prediction, its cached target, the shared counter and the replacement ages. A branch that is not yet in the table gets a new entry in the same operation. A flush input empties the table and leaves the shared counters as they are.

Top module: `pa_branch_table`

## Requirements
- R1: An address splits into a set index (its low `log2(SETS)` bits) and a tag (all remaining high bits). A lookup hits only when a valid way of that set holds the same tag. The result appears on `pred_*` one cycle after `fetch_valid`, with `pred_valid` high for exactly that cycle. All `pred_*` outputs are 0 after reset.
- R2: On a hit, `pred_taken` equals the entry's stored prediction bit. `pred_next` is the cached target when that bit is 1, and the fetch address plus `FETCH_STEP` (default 4) when it is 0.
- R3: On a miss, `pred_hit` and `pred_taken` are 0 and `pred_next` is the fetch address plus `FETCH_STEP`.
- R4: A lookup never changes table state. A lookup in the same cycle as a resolve or a flush sees the table as it was before that resolve or flush.
- R5: A resolve whose address misses allocates an entry in its set. The entry's history is treated as all ones, so the shared counter at index all-ones is the one updated. The stored history then becomes the outcome copied into every bit, and the target is written.
- R6: A resolve that hits forms its new history by shifting the old history left and inserting the outcome (1 = taken) at bit 0. It increments (taken) or decrements (not taken) the shared counter indexed by the old history, saturating at 0 and 3.
- R7: The stored prediction bit is 1 when the shared counter at the new history, after this resolve's own update, is 2 or more.
- R8: The cached target is overwritten by a taken resolve and by an allocation. A not-taken resolve that hits keeps the old target.
- R9: Every way has an age. Reset and flush give way w age w. A resolve (hit or allocation) sets the touched way to age 0 and adds one to each way younger than it. An allocation replaces the way whose age is `WAYS-1`.
- R10: `flush` invalidates every entry and restores the ages. The shared counters keep their values. A resolve in the same cycle as a flush has no effect.
- R11: After reset every shared counter holds 1 (weakly not taken).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate the whole table (context switch) |
| fetch_valid | input | 1 | Lookup request |
| fetch_addr | input | ADDR_W | Fetch address to look up |
| pred_valid | output | 1 | Lookup result valid |
| pred_hit | output | 1 | Address found in the table |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_next | output | ADDR_W | Next fetch address |
| res_valid | input | 1 | Resolved branch present |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_target | input | ADDR_W | Actual branch target |

## Verification
Lookup results are registered, so a request issued in one cycle has its answer on `pred_*` after exactly one rising edge. The bench drives each request on a falling edge and compares at the next falling edge. A resolve or flush takes effect at the rising edge that samples it, so it is visible only to lookups issued in later cycles. The bench therefore updates its own reference model after that edge, and it compares a lookup issued in the same cycle against the state before the update. A pseudo-random mix of resolves and lookups on a few colliding sets is checked against that reference model.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_INIT = 2'd1;

   // saturating up/down step of a 2-bit pattern counter
   function automatic ctr_t ctr_step(input ctr_t c, input logic up);
      if (up) return (c == 2'd3) ? c : c + 2'd1;
      else    return (c == 2'd0) ? c : c - 2'd1;
   endfunction

endpackage

// File: rtl/bpt_way_match.sv
module bpt_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 25,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_vld,
   input  logic [TAG_W-1:0]           probe,
   output logic                       hit,
   output logic [WAY_W-1:0]           way
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_vld[w] && (way_tag[w] == probe);
   end

   always_comb begin
      hit = |match;
      way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/bpt_age_lru.sv
module bpt_age_lru #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0][WAY_W-1:0] age_in,
   input  logic [WAY_W-1:0]           touch,
   output logic [WAYS-1:0][WAY_W-1:0] age_out,
   output logic [WAY_W-1:0]           victim
);

   if (WAYS == 1) begin : g_direct
      assign age_out = '0;
      assign victim  = '0;
      logic unused_ok;
      assign unused_ok = ^{age_in, touch};
   end else begin : g_assoc
      logic [WAY_W-1:0] touched_age;
      assign touched_age = age_in[touch];

      always_comb begin
         victim = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (age_in[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
         end
      end

      for (genvar w = 0; w < WAYS; w++) begin : g_age
         always_comb begin
            if (touch == WAY_W'(w))             age_out[w] = '0;
            else if (age_in[w] < touched_age)   age_out[w] = age_in[w] + 1'b1;
            else                                age_out[w] = age_in[w];
         end
      end
   end

endmodule

// File: rtl/bpt_pattern_table.sv
module bpt_pattern_table
   import bpt_pkg::*;
#(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_en,
   input  logic [HIST_W-1:0] upd_idx,
   input  logic              upd_up,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken
);

   localparam int ENTRIES = 1 << HIST_W;

   ctr_t ctr_q [ENTRIES];
   ctr_t upd_val;

   assign upd_val = ctr_step(ctr_q[upd_idx], upd_up);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
      end else if (upd_en) begin
         ctr_q[upd_idx] <= upd_val;
      end
   end

   // read of the new index sees this cycle's update when both indices agree
   always_comb begin
      if (upd_en && (rd_idx == upd_idx)) rd_taken = upd_val[1];
      else                               rd_taken = ctr_q[rd_idx][1];
   end

endmodule

// File: rtl/pa_branch_table.sv
module pa_branch_table #(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 4,
   parameter int HIST_W     = 8,
   parameter int FETCH_STEP = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flush,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              pred_valid,
   output logic              pred_hit,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_next,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_addr,
   input  logic              res_taken,
   input  logic [ADDR_W-1:0] res_target
);

   localparam int SET_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - SET_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   // elaboration-time parameter checks
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 1 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if (HIST_W < 2 || HIST_W > 16) begin : g_bad_hist
      $error("HIST_W must lie in 2..16");
   end
   if (ADDR_W <= SET_W) begin : g_bad_addr
      $error("ADDR_W must exceed the set index width");
   end

   // table storage
   logic [WAYS-1:0]              vld_q  [SETS];
   logic [WAYS-1:0][WAY_W-1:0]   age_q  [SETS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
   logic [WAYS-1:0][HIST_W-1:0]  hist_q [SETS];
   logic [WAYS-1:0]              pbit_q [SETS];
   logic [WAYS-1:0][ADDR_W-1:0]  tgt_q  [SETS];

   // lookup side
   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic             lk_hit;
   logic [WAY_W-1:0] lk_way;
   logic             lk_pbit;
   logic [ADDR_W-1:0] lk_seq;

   assign lk_set = fetch_addr[SET_W-1:0];
   assign lk_tag = fetch_addr[ADDR_W-1:SET_W];
   assign lk_seq = fetch_addr + ADDR_W'(FETCH_STEP);

   bpt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
      .way_tag (tag_q[lk_set]),
      .way_vld (vld_q[lk_set]),
      .probe   (lk_tag),
      .hit     (lk_hit),
      .way     (lk_way)
   );

   assign lk_pbit = lk_hit && pbit_q[lk_set][lk_way];

   always_ff @(posedge clk) begin
      if (rst) begin
         pred_valid <= 1'b0;
         pred_hit   <= 1'b0;
         pred_taken <= 1'b0;
         pred_next  <= '0;
      end else begin
         pred_valid <= fetch_valid;
         if (fetch_valid) begin
            pred_hit   <= lk_hit;
            pred_taken <= lk_pbit;
            pred_next  <= lk_pbit ? tgt_q[lk_set][lk_way] : lk_seq;
         end
      end
   end

   // resolve side
   logic [SET_W-1:0]           rs_set;
   logic [TAG_W-1:0]           rs_tag;
   logic                       rs_hit;
   logic [WAY_W-1:0]           rs_hit_way;
   logic [WAY_W-1:0]           rs_victim;
   logic [WAY_W-1:0]           rs_way;
   logic [WAYS-1:0][WAY_W-1:0] rs_age_new;
   logic [HIST_W-1:0]          old_hist;
   logic [HIST_W-1:0]          new_hist;
   logic                       new_pbit;
   logic                       rs_go;

   assign rs_set = res_addr[SET_W-1:0];
   assign rs_tag = res_addr[ADDR_W-1:SET_W];
   assign rs_go  = res_valid && !flush;

   bpt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_rs_match (
      .way_tag (tag_q[rs_set]),
      .way_vld (vld_q[rs_set]),
      .probe   (rs_tag),
      .hit     (rs_hit),
      .way     (rs_hit_way)
   );

   bpt_age_lru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
      .age_in  (age_q[rs_set]),
      .touch   (rs_way),
      .age_out (rs_age_new),
      .victim  (rs_victim)
   );

   assign rs_way   = rs_hit ? rs_hit_way : rs_victim;
   assign old_hist = rs_hit ? hist_q[rs_set][rs_hit_way] : '1;
   assign new_hist = rs_hit ? {old_hist[HIST_W-2:0], res_taken} : {HIST_W{res_taken}};

   bpt_pattern_table #(.HIST_W(HIST_W)) u_pht (
      .clk      (clk),
      .rst      (rst),
      .upd_en   (rs_go),
      .upd_idx  (old_hist),
      .upd_up   (res_taken),
      .rd_idx   (new_hist),
      .rd_taken (new_pbit)
   );

   // valid bits and ages: reset and flush
   always_ff @(posedge clk) begin
      if (rst || flush) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else if (res_valid) begin
         vld_q[rs_set][rs_way] <= 1'b1;
         age_q[rs_set]         <= rs_age_new;
      end
   end

   // entry payload: guarded by the valid bits, no reset needed
   always_ff @(posedge clk) begin
      if (rs_go && !rst) begin
         tag_q[rs_set][rs_way]  <= rs_tag;
         hist_q[rs_set][rs_way] <= new_hist;
         pbit_q[rs_set][rs_way] <= new_pbit;
         if (res_taken || !rs_hit) tgt_q[rs_set][rs_way] <= res_target;
      end
   end

endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
   parameter int ADDR_W     = 32,
   parameter int FETCH_STEP = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              flush,
   input logic              fetch_valid,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              pred_valid,
   input logic              pred_hit,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_next
);

   p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
      fetch_valid |=> pred_valid);

   p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      !fetch_valid |=> !pred_valid);

   p_miss_seq_r3: assert property (@(posedge clk) disable iff (rst)
      fetch_valid ##1 (pred_valid && !pred_hit)
      |-> (!pred_taken && pred_next == $past(fetch_addr) + ADDR_W'(FETCH_STEP)));

   p_nt_hit_seq_r2: assert property (@(posedge clk) disable iff (rst)
      fetch_valid ##1 (pred_valid && pred_hit && !pred_taken)
      |-> (pred_next == $past(fetch_addr) + ADDR_W'(FETCH_STEP)));

   p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
      (flush ##1 fetch_valid) |=> !pred_hit);

endmodule

bind pa_branch_table bpt_checker #(.ADDR_W(ADDR_W), .FETCH_STEP(FETCH_STEP)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .flush       (flush),
   .fetch_valid (fetch_valid),
   .fetch_addr  (fetch_addr),
   .pred_valid  (pred_valid),
   .pred_hit    (pred_hit),
   .pred_taken  (pred_taken),
   .pred_next   (pred_next)
);

// File: tb/pa_branch_table_test.sv
module pa_branch_table_test;

   localparam int AW   = 32;
   localparam int NS   = 128;
   localparam int NW   = 4;
   localparam int HW   = 8;
   localparam int STEP = 4;
   localparam int SW   = 7;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          flush = 1'b0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          pred_valid, pred_hit, pred_taken;
   logic [AW-1:0] pred_next;
   logic          res_valid = 1'b0;
   logic [AW-1:0] res_addr = '0;
   logic          res_taken = 1'b0;
   logic [AW-1:0] res_target = '0;

   always #5 clk = ~clk;

   pa_branch_table #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .HIST_W(HW), .FETCH_STEP(STEP)) uut (
      .clk(clk), .rst(rst), .flush(flush),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next(pred_next),
      .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken), .res_target(res_target)
   );

   int checks = 0;
   int fails  = 0;

   // reference model built from the requirements
   bit            m_vld  [NS][NW];
   logic [AW-1:0] m_tag  [NS][NW];
   logic [HW-1:0] m_hist [NS][NW];
   bit            m_pbit [NS][NW];
   logic [AW-1:0] m_tgt  [NS][NW];
   int            m_age  [NS][NW];
   logic [1:0]    m_ctr  [1<<HW];

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic m_flush();
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            m_vld[s][w] = 1'b0;
            m_age[s][w] = w;
         end
   endtask

   function automatic logic [1:0] m_step(input logic [1:0] c, input bit up);
      if (up) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   task automatic m_resolve(input logic [AW-1:0] a, input bit t, input logic [AW-1:0] tg);
      int s, way, old_age;
      bit hit;
      logic [HW-1:0] oh, nh;
      s = int'(a[SW-1:0]);
      hit = 1'b0; way = 0;
      for (int w = 0; w < NW; w++)
         if (m_vld[s][w] && m_tag[s][w] == (a >> SW)) begin hit = 1'b1; way = w; end
      if (!hit)
         for (int w = 0; w < NW; w++) if (m_age[s][w] == NW - 1) way = w;
      oh = hit ? m_hist[s][way] : '1;
      nh = hit ? {oh[HW-2:0], t} : {HW{t}};
      m_ctr[oh] = m_step(m_ctr[oh], t);
      m_pbit[s][way] = m_ctr[nh][1];
      if (t || !hit) m_tgt[s][way] = tg;
      old_age = m_age[s][way];
      for (int w = 0; w < NW; w++)
         if (w == way) m_age[s][w] = 0;
         else if (m_age[s][w] < old_age) m_age[s][w]++;
      m_vld[s][way] = 1'b1;
      m_tag[s][way] = a >> SW;
      m_hist[s][way] = nh;
   endtask

   // expected {hit, taken, next}
   function automatic logic [AW+1:0] m_lookup(input logic [AW-1:0] a);
      int s;
      s = int'(a[SW-1:0]);
      for (int w = 0; w < NW; w++)
         if (m_vld[s][w] && m_tag[s][w] == (a >> SW))
            return {1'b1, m_pbit[s][w], m_pbit[s][w] ? m_tgt[s][w] : a + AW'(STEP)};
      return {1'b0, 1'b0, a + AW'(STEP)};
   endfunction

   // all drive tasks start and end at a falling edge
   task automatic do_resolve(input logic [AW-1:0] a, input bit t, input logic [AW-1:0] tg);
      res_valid = 1'b1; res_addr = a; res_taken = t; res_target = tg;
      @(negedge clk);
      res_valid = 1'b0;
      m_resolve(a, t, tg);
   endtask

   task automatic do_lookup(input string req, input logic [AW-1:0] a, output logic [AW+1:0] got);
      logic [AW+1:0] exp;
      exp = m_lookup(a);
      fetch_valid = 1'b1; fetch_addr = a;
      @(negedge clk);
      fetch_valid = 1'b0;
      got = {pred_hit, pred_taken, pred_next};
      check({req, " valid"}, 64'(pred_valid), 64'(1));
      check(req, 64'(got), 64'(exp));
   endtask

   task automatic do_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      m_flush();
   endtask

   function automatic logic [AW-1:0] in_set(input int tag, input int s);
      return AW'((tag << SW) | s);
   endfunction

   task automatic t_reset();
      logic [AW+1:0] g;
      check("R1 reset outputs", 64'({pred_valid, pred_hit, pred_taken, pred_next}), 64'(0));
      do_lookup("R3 empty lookup", 32'h0000_1000, g);
      check("R3 miss literal", 64'(g), 64'({2'b00, 32'h0000_1004}));
      @(negedge clk);
      check("R1 valid drops", 64'(pred_valid), 64'(0));
   endtask

   task automatic t_alloc();
      logic [AW+1:0] g;
      do_resolve(32'h0000_1234, 1'b1, 32'h0000_8000);
      do_lookup("R5 R7 R11 alloc taken", 32'h0000_1234, g);
      check("R5 literal", 64'(g), 64'({2'b11, 32'h0000_8000}));
      do_resolve(32'h0000_2238, 1'b0, 32'h0000_9000);
      do_lookup("R5 R7 alloc not taken", 32'h0000_2238, g);
      check("R7 literal", 64'(g), 64'({2'b10, 32'h0000_223C}));
      do_lookup("R2 stored bit kept", 32'h0000_1234, g);
      check("R2 literal", 64'(g), 64'({2'b11, 32'h0000_8000}));
   endtask

   task automatic t_history();
      logic [AW+1:0] g;
      bit pat [12] = '{1,1,0,1,1,0,1,1,0,0,1,1};
      for (int i = 0; i < 12; i++) begin
         do_resolve(32'h0000_1234, pat[i], 32'h0000_A000 + AW'(i * 16));
         do_lookup("R6 R7 R8 history step", 32'h0000_1234, g);
      end
      for (int i = 0; i < 6; i++) begin
         do_resolve(32'h0000_3310, 1'b1, 32'h0000_C000 + AW'(i * 8));
         do_resolve(32'h0000_3310, 1'b0, 32'h0000_D000);
         do_lookup("R8 not-taken keeps target", 32'h0000_3310, g);
      end
   endtask

   task automatic t_lru();
      logic [AW+1:0] g;
      for (int t = 1; t <= 4; t++) do_resolve(in_set(t, 5), 1'b1, 32'h0000_5000 + AW'(t));
      do_resolve(in_set(1, 5), 1'b1, 32'h0000_5001);
      do_resolve(in_set(5, 5), 1'b0, 32'h0000_5005);
      do_lookup("R9 refreshed way kept", in_set(1, 5), g);
      check("R9 tag1 hit", 64'(g[AW+1]), 64'(1));
      do_lookup("R9 oldest evicted", in_set(2, 5), g);
      check("R9 tag2 miss", 64'(g[AW+1]), 64'(0));
      do_lookup("R9 tag3", in_set(3, 5), g);
      check("R9 tag3 hit", 64'(g[AW+1]), 64'(1));
      do_lookup("R9 tag5", in_set(5, 5), g);
      check("R9 tag5 hit", 64'(g[AW+1]), 64'(1));
   endtask

   task automatic t_same_cycle();
      logic [AW+1:0] g;
      fetch_valid = 1'b1; fetch_addr = 32'h0000_4440;
      res_valid = 1'b1; res_addr = 32'h0000_4440; res_taken = 1'b1; res_target = 32'h0000_E000;
      @(negedge clk);
      fetch_valid = 1'b0; res_valid = 1'b0;
      check("R4 lookup sees old state", 64'({pred_hit, pred_taken, pred_next}),
            64'({2'b00, 32'h0000_4444}));
      m_resolve(32'h0000_4440, 1'b1, 32'h0000_E000);
      do_lookup("R4 visible next cycle", 32'h0000_4440, g);
      check("R4 hit after", 64'(g[AW+1]), 64'(1));
   endtask

   task automatic t_flush();
      logic [AW+1:0] g;
      do_flush();
      do_lookup("R10 flushed entry", 32'h0000_1234, g);
      check("R10 miss after flush", 64'(g[AW+1]), 64'(0));
      flush = 1'b1;
      res_valid = 1'b1; res_addr = 32'h0000_6660; res_taken = 1'b1; res_target = 32'h0000_F000;
      @(negedge clk);
      flush = 1'b0; res_valid = 1'b0;
      m_flush();
      do_lookup("R10 resolve with flush dropped", 32'h0000_6660, g);
      check("R10 dropped miss", 64'(g[AW+1]), 64'(0));
      // counters kept across the flush: the model carries them on
      do_resolve(32'h0000_1234, 1'b1, 32'h0000_8100);
      do_lookup("R10 counters kept", 32'h0000_1234, g);
      do_resolve(32'h0000_7770, 1'b0, 32'h0000_8200);
      do_lookup("R10 counters kept nt", 32'h0000_7770, g);
   endtask

   task automatic t_mixed();
      logic [AW+1:0] g;
      logic [15:0] lf = 16'hACE1;
      int sets [3] = '{3, 9, 77};
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         a = in_set(int'(lf[6:4]) % 6 + 1, sets[int'(lf[9:8]) % 3]);
         if (lf[0]) do_resolve(a, lf[3] ^ lf[11], {14'd0, lf, 2'b00});
         else       do_lookup("R6 R7 R9 mixed traffic", a, g);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << HW); i++) m_ctr[i] = 2'd1;
      m_flush();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_history();
      t_lru();
      t_same_cycle();
      t_flush();
      t_mixed();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule